// File: doc/BRIEF.md
# Event-Mapped Delayed Pulse Generator

This block sits behind a timing-link receiver and turns each received 8-bit event code into output actions. The code indexes one of two 256-entry by 16-bit mapping tables, and the 16-bit word it reads back is an action mask. Mask bit `i` fires pulse generator `i`. Each adjacent pair of mask bits drives one level output: one bit of the pair sets the level and the other clears it. Software fills both tables through a simple write port, so one table can be rewritten while the other is in use. A select input chooses the active table for each lookup.

Each pulse generator holds a programmable delay, width, prescaler and polarity. When a generator fires, its output goes active after delay×prescale clocks and stays active for width×prescale clocks. The prescaler stretches both intervals, so long delays need no wider counters. A generator that is already waiting or pulsing ignores any new trigger. A generator whose width is zero never pulses.

Top module: `evmap_pulse_unit`

## Requirements
- R1: There are two mapping tables of 256 entries × 16 bits. A write with `map_wr_en` high stores `map_wr_data` at `map_wr_addr` in the table named by `map_wr_bank` (0 or 1). It leaves the other table unchanged.
- R2: If `ev_valid` is high in cycle n, the word at `ev_code` in the selected table takes effect on the clock edge that ends cycle n+1. Level outputs show the new value from cycle n+2. Without a received code the level outputs hold.
- R3: `bank_sel` is sampled only in the cycle in which `ev_valid` is high. A change of `bank_sel` at any other time, including the cycle right after a code, has no effect until the next received code.
- R4: Mask bit i (i < NUM_PULSE) fires generator i. Count cycles from k=0, the first cycle after the trigger edge. The output is active for k = D·P through D·P + W·P − 1, where D is the delay, W the width and P the prescaler. A prescaler of 0 acts as 1.
- R5: For level output j, mask bit 2j+1 sets the output to 1 and mask bit 2j clears it to 0. When both bits are set, the set wins. When neither is set, the output keeps its value.
- R6: `pulse_out[i]` is the generator's active state XOR its polarity bit. With polarity 1 the output idles high and pulses low.
- R7: A trigger that arrives while a generator is waiting or pulsing is ignored. The pulse in progress keeps its timing and no second pulse follows it.
- R8: A generator whose width is 0 stays idle when triggered and produces no pulse.
- R9: After reset all level outputs are 0, every configuration field is 0 and every pulse output is 0.
- R10: A configuration write with `cfg_wr_en` high goes to generator `cfg_wr_gen`. `cfg_wr_field` selects the target: 0 for delay, 1 for width, 2 for prescaler, 3 for polarity (data bit 0). `cfg_wr_data` is truncated to the field width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Event clock |
| rst_n | input | 1 | Synchronous active-low reset |
| map_wr_en | input | 1 | Mapping table write strobe |
| map_wr_bank | input | 1 | Table written (0 or 1) |
| map_wr_addr | input | 8 | Entry written |
| map_wr_data | input | 16 | Action mask stored |
| bank_sel | input | 1 | Table used for the lookup of a code received this cycle |
| ev_valid | input | 1 | A received event code is present |
| ev_code | input | 8 | Received event code |
| cfg_wr_en | input | 1 | Generator configuration write strobe |
| cfg_wr_gen | input | 2 | Generator addressed |
| cfg_wr_field | input | 2 | Field: 0 delay, 1 width, 2 prescaler, 3 polarity |
| cfg_wr_data | input | 32 | Field value |
| pulse_out | output | 4 | Pulse generator outputs after polarity |
| level_out | output | 8 | Level outputs driven by mask bit pairs |

## Verification
A wrong table entry or a bank picked at the wrong time shows on `level_out` two cycles after the code arrives. This is why every random lookup is followed by a level compare at exactly that cycle. A generator counter that is off by one or a prescaler reload that slips moves the start or the length of the pulse. The pulse is measured cycle by cycle against D·P and W·P, so an error of a single clock is visible. A generator that re-arms on a retrigger shows up as a second rising edge within the measured window.

// File: rtl/evmap_pkg.sv
// Shared constants and types for the event-mapped pulse unit.
// Assumes event codes are 8 bits wide and mapping words are 16 bits wide.
package evmap_pkg;
    localparam int CODE_W = 8;
    localparam int MAP_W  = 16;
    localparam int CFG_W  = 32;

    typedef enum logic [1:0] {
        FLD_DELAY = 2'd0,
        FLD_WIDTH = 2'd1,
        FLD_PRESC = 2'd2,
        FLD_POL   = 2'd3
    } cfg_field_e;

    typedef enum logic [1:0] {
        PG_IDLE = 2'd0,
        PG_WAIT = 2'd1,
        PG_HIGH = 2'd2
    } pg_state_e;
endpackage

// File: rtl/evmap_table.sv
// Two mapping tables with a registered lookup.
// What it does: writes go to the table named by wr_sel. A lookup reads the table
// named by look_sel in the same cycle as look_en, so a later change of the select
// cannot disturb a lookup in flight.
// Assumes: the table contents are not reset; software fills them before use.
module evmap_table #(
    parameter int CODE_W = 8,
    parameter int MAP_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [CODE_W-1:0] wr_addr,
    input  logic [MAP_W-1:0]  wr_data,
    input  logic              look_en,
    input  logic              look_sel,
    input  logic [CODE_W-1:0] look_code,
    output logic              hit,
    output logic [MAP_W-1:0]  word
);
    localparam int DEPTH = 1 << CODE_W;

    logic [MAP_W-1:0] bank_rd [2];

    for (genvar t = 0; t < 2; t++) begin : g_bank
        logic [MAP_W-1:0] mem [DEPTH];

        // Store one entry when this bank is the write target.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_sel == 1'(t))) begin
                mem[wr_addr] <= wr_data;
            end
        end

        assign bank_rd[t] = mem[look_code];
    end

    // Capture the selected bank's word and flag it for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit  <= 1'b0;
            word <= '0;
        end else begin
            hit <= look_en;
            if (look_en) begin
                word <= bank_rd[look_sel];
            end
        end
    end
endmodule

// File: rtl/evmap_pulse_gen.sv
// One delayed pulse generator with a prescaled delay and width.
// What it does: on fire while idle, with a nonzero width, it waits delay*prescale
// clocks, stays active for width*prescale clocks, then returns to idle. A trigger
// that arrives while it is not idle is ignored. Width and prescaler are captured
// at the trigger.
// Assumes: a prescaler of 0 is treated as 1.
module evmap_pulse_gen #(
    parameter int DLY_W = 32,
    parameter int WID_W = 32,
    parameter int PS_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [DLY_W-1:0] cfg_delay,
    input  logic [WID_W-1:0] cfg_width,
    input  logic [PS_W-1:0]  cfg_presc,
    input  logic             cfg_pol,
    output logic             pulse,
    output logic             busy,
    output logic             active
);
    import evmap_pkg::*;

    localparam int CNT_W = (DLY_W > WID_W) ? DLY_W : WID_W;

    pg_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic [PS_W-1:0]  pc;
    logic [PS_W-1:0]  reload_q;
    logic [WID_W-1:0] width_q;
    logic [PS_W-1:0]  reload_now;

    // Prescaler reload value: the terminal count is prescale minus one.
    always_comb begin
        reload_now = (cfg_presc == '0) ? '0 : cfg_presc - 1'b1;
    end

    // Sequence through idle, delay wait and active phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= PG_IDLE;
            cnt      <= '0;
            pc       <= '0;
            reload_q <= '0;
            width_q  <= '0;
        end else begin
            case (state)
                PG_IDLE: begin
                    if (fire && (cfg_width != '0)) begin
                        width_q  <= cfg_width;
                        reload_q <= reload_now;
                        pc       <= reload_now;
                        if (cfg_delay == '0) begin
                            state <= PG_HIGH;
                            cnt   <= CNT_W'(cfg_width);
                        end else begin
                            state <= PG_WAIT;
                            cnt   <= CNT_W'(cfg_delay);
                        end
                    end
                end
                default: begin
                    if (pc == '0) begin
                        pc <= reload_q;
                        if (cnt == CNT_W'(1)) begin
                            if (state == PG_WAIT) begin
                                state <= PG_HIGH;
                                cnt   <= CNT_W'(width_q);
                            end else begin
                                state <= PG_IDLE;
                                cnt   <= '0;
                            end
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end else begin
                        pc <= pc - 1'b1;
                    end
                end
            endcase
        end
    end

    assign busy   = (state != PG_IDLE);
    assign active = (state == PG_HIGH);
    assign pulse  = active ^ cfg_pol;
endmodule

// File: rtl/evmap_level_bank.sv
// Level outputs controlled by pairs of mapping bits.
// What it does: for output j, mask bit 2j+1 sets it and mask bit 2j clears it.
// The set wins when both are present.
// Assumes: the word is valid only in a cycle where hit is high.
module evmap_level_bank #(
    parameter int NUM_LEVEL = 8,
    parameter int MAP_W     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hit,
    input  logic [MAP_W-1:0]     word,
    output logic [NUM_LEVEL-1:0] lvl
);
    for (genvar j = 0; j < NUM_LEVEL; j++) begin : g_lvl
        // Apply the set or clear request of this output's bit pair.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lvl[j] <= 1'b0;
            end else if (hit && word[2*j+1]) begin
                lvl[j] <= 1'b1;
            end else if (hit && word[2*j]) begin
                lvl[j] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/evmap_pulse_unit.sv
// Top level: event code lookup, per-generator configuration, pulse generators
// and level outputs.
// What it does: a received code picks a word from the active table. Bit i of the
// word fires generator i, and bit pairs drive the level outputs.
// Assumes: the field widths are not wider than the configuration data port, and
// NUM_PULSE is not larger than the mapping word width.
module evmap_pulse_unit #(
    parameter int NUM_PULSE = 4,
    parameter int DLY_W     = 32,
    parameter int WID_W     = 32,
    parameter int PS_W      = 16,
    localparam int GSEL_W   = (NUM_PULSE > 1) ? $clog2(NUM_PULSE) : 1,
    localparam int NUM_LVL  = evmap_pkg::MAP_W / 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        map_wr_en,
    input  logic                        map_wr_bank,
    input  logic [evmap_pkg::CODE_W-1:0] map_wr_addr,
    input  logic [evmap_pkg::MAP_W-1:0]  map_wr_data,
    input  logic                        bank_sel,
    input  logic                        ev_valid,
    input  logic [evmap_pkg::CODE_W-1:0] ev_code,
    input  logic                        cfg_wr_en,
    input  logic [GSEL_W-1:0]           cfg_wr_gen,
    input  logic [1:0]                  cfg_wr_field,
    input  logic [evmap_pkg::CFG_W-1:0] cfg_wr_data,
    output logic [NUM_PULSE-1:0]        pulse_out,
    output logic [NUM_LVL-1:0]          level_out
);
    import evmap_pkg::*;

    logic                               look_hit;
    logic [MAP_W-1:0]                   look_word;
    logic [NUM_PULSE-1:0][DLY_W-1:0]    cfg_delay;
    logic [NUM_PULSE-1:0][WID_W-1:0]    cfg_width;
    logic [NUM_PULSE-1:0][PS_W-1:0]     cfg_presc;
    logic [NUM_PULSE-1:0]               cfg_pol;
    logic [NUM_PULSE-1:0]               gen_busy;
    logic [NUM_PULSE-1:0]               gen_act;

    evmap_table #(.CODE_W(CODE_W), .MAP_W(MAP_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (map_wr_en),
        .wr_sel    (map_wr_bank),
        .wr_addr   (map_wr_addr),
        .wr_data   (map_wr_data),
        .look_en   (ev_valid),
        .look_sel  (bank_sel),
        .look_code (ev_code),
        .hit       (look_hit),
        .word      (look_word)
    );

    for (genvar g = 0; g < NUM_PULSE; g++) begin : g_gen
        // Hold this generator's configuration fields, written one at a time.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_delay[g] <= '0;
                cfg_width[g] <= '0;
                cfg_presc[g] <= '0;
                cfg_pol[g]   <= 1'b0;
            end else if (cfg_wr_en && (cfg_wr_gen == GSEL_W'(g))) begin
                case (cfg_field_e'(cfg_wr_field))
                    FLD_DELAY: cfg_delay[g] <= DLY_W'(cfg_wr_data);
                    FLD_WIDTH: cfg_width[g] <= WID_W'(cfg_wr_data);
                    FLD_PRESC: cfg_presc[g] <= PS_W'(cfg_wr_data);
                    default:   cfg_pol[g]   <= cfg_wr_data[0];
                endcase
            end
        end

        evmap_pulse_gen #(.DLY_W(DLY_W), .WID_W(WID_W), .PS_W(PS_W)) u_pg (
            .clk       (clk),
            .rst_n     (rst_n),
            .fire      (look_hit && look_word[g]),
            .cfg_delay (cfg_delay[g]),
            .cfg_width (cfg_width[g]),
            .cfg_presc (cfg_presc[g]),
            .cfg_pol   (cfg_pol[g]),
            .pulse     (pulse_out[g]),
            .busy      (gen_busy[g]),
            .active    (gen_act[g])
        );
    end

    evmap_level_bank #(.NUM_LEVEL(NUM_LVL), .MAP_W(MAP_W)) u_levels (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (look_hit),
        .word  (look_word),
        .lvl   (level_out)
    );
endmodule

// File: rtl/evmap_checker.sv
// Assertion checker for evmap_pulse_unit, attached with bind.
// What it does: relates the registered lookup to the level outputs and to the
// generator states.
// Assumes: it is bound into evmap_pulse_unit with the connections given below.
module evmap_checker #(
    parameter int NUM_PULSE = 4,
    parameter int NUM_LVL   = 8,
    parameter int MAP_W     = 16,
    parameter int WID_W     = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          ev_valid,
    input logic                          hit,
    input logic [MAP_W-1:0]              word,
    input logic [NUM_LVL-1:0]            level_out,
    input logic [NUM_PULSE-1:0]          busy,
    input logic [NUM_PULSE-1:0]          act,
    input logic [NUM_PULSE-1:0][WID_W-1:0] cfg_width
);
    // R2: a received code yields a lookup result one cycle later.
    p_lookup_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |=> hit);

    // R2: without a lookup result the level outputs hold.
    p_level_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(level_out));

    for (genvar j = 0; j < NUM_LVL; j++) begin : g_lvl_chk
        // R5: the odd bit of a pair sets the output and wins over the even bit.
        p_level_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && word[2*j+1]) |=> level_out[j]);
        // R5: the even bit alone clears the output.
        p_level_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && word[2*j] && !word[2*j+1]) |=> !level_out[j]);
    end

    for (genvar i = 0; i < NUM_PULSE; i++) begin : g_pg_chk
        // R8: a zero width keeps an idle generator idle when it is fired.
        p_zero_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && word[i] && !busy[i] && (cfg_width[i] == '0)) |=> !busy[i]);
        // R7: after its active phase a generator is idle or still active, never waiting again.
        p_no_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
            act[i] |=> (act[i] || !busy[i]));
    end
endmodule

bind evmap_pulse_unit evmap_checker #(
    .NUM_PULSE (NUM_PULSE),
    .NUM_LVL   (NUM_LVL),
    .MAP_W     (evmap_pkg::MAP_W),
    .WID_W     (WID_W)
) u_evmap_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_valid  (ev_valid),
    .hit       (look_hit),
    .word      (look_word),
    .level_out (level_out),
    .busy      (gen_busy),
    .act       (gen_act),
    .cfg_width (cfg_width)
);

// File: tb/tb_evmap_pulse_unit.sv
`timescale 1ns/1ps
module tb_evmap_pulse_unit;
    localparam int NP = 4;
    localparam int NL = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        map_wr_en = 1'b0;
    logic        map_wr_bank = 1'b0;
    logic [7:0]  map_wr_addr = '0;
    logic [15:0] map_wr_data = '0;
    logic        bank_sel = 1'b0;
    logic        ev_valid = 1'b0;
    logic [7:0]  ev_code = '0;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_wr_gen = '0;
    logic [1:0]  cfg_wr_field = '0;
    logic [31:0] cfg_wr_data = '0;
    logic [NP-1:0] pulse_out;
    logic [NL-1:0] level_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [15:0]   shadow [2][256];
    logic [NL-1:0] exp_lvl = '0;
    logic [NP-1:0] exp_pol = '0;

    evmap_pulse_unit dut (
        .clk(clk), .rst_n(rst_n),
        .map_wr_en(map_wr_en), .map_wr_bank(map_wr_bank),
        .map_wr_addr(map_wr_addr), .map_wr_data(map_wr_data),
        .bank_sel(bank_sel), .ev_valid(ev_valid), .ev_code(ev_code),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_gen(cfg_wr_gen),
        .cfg_wr_field(cfg_wr_field), .cfg_wr_data(cfg_wr_data),
        .pulse_out(pulse_out), .level_out(level_out)
    );

    always #2.5 clk = ~clk;

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected level update from one mask word (R5).
    function automatic logic [NL-1:0] apply_levels(input logic [NL-1:0] cur, input logic [15:0] w);
        logic [NL-1:0] nxt = cur;
        for (int j = 0; j < NL; j++) begin
            if (w[2*j+1]) nxt[j] = 1'b1;
            else if (w[2*j]) nxt[j] = 1'b0;
        end
        return nxt;
    endfunction

    task automatic map_write(input bit bank, input logic [7:0] addr, input logic [15:0] data);
        map_wr_en = 1'b1; map_wr_bank = bank; map_wr_addr = addr; map_wr_data = data;
        shadow[bank][addr] = data;
        @(negedge clk);
        map_wr_en = 1'b0;
    endtask

    task automatic cfg_write(input int gen, input logic [1:0] fld, input logic [31:0] data);
        cfg_wr_en = 1'b1; cfg_wr_gen = 2'(gen); cfg_wr_field = fld; cfg_wr_data = data;
        if (fld == 2'd3) exp_pol[gen] = data[0];
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic set_gen(input int gen, input int d, input int w, input int p, input bit pol);
        cfg_write(gen, 2'd0, 32'(d));
        cfg_write(gen, 2'd1, 32'(w));
        cfg_write(gen, 2'd2, 32'(p));
        cfg_write(gen, 2'd3, {31'b0, pol});
    endtask

    // Drive one code for one cycle; optionally flip bank_sel in the following cycle (R3).
    task automatic send_code(input logic [7:0] code, input bit bank, input bit flip_after);
        ev_valid = 1'b1; ev_code = code; bank_sel = bank;
        exp_lvl = apply_levels(exp_lvl, shadow[bank][code]);
        @(negedge clk);
        ev_valid = 1'b0;
        if (flip_after) bank_sel = ~bank;
    endtask

    // Fire a generator and record pulse start, length and rising edges (R4).
    task automatic measure(input logic [7:0] code, input int gen, input int retrig_at,
                           input int window, output int first, output int len, output int rises);
        bit prev = 1'b0;
        first = -1; len = 0; rises = 0;
        send_code(code, 1'b0, 1'b0);
        for (int k = 0; k < window; k++) begin
            @(negedge clk);
            ev_valid = 1'b0;
            if (pulse_out[gen] ^ exp_pol[gen]) begin
                if (first < 0) first = k;
                len++;
                if (!prev) rises++;
                prev = 1'b1;
            end else begin
                prev = 1'b0;
            end
            if (k == retrig_at) begin
                ev_valid = 1'b1; ev_code = code; bank_sel = 1'b0;
                exp_lvl = apply_levels(exp_lvl, shadow[0][code]);
            end
        end
    endtask

    initial begin
        int first, len, rises;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);

        // R9: reset state.
        check(level_out == '0, "R9 level reset", 32'(level_out), 0);
        check(pulse_out == '0, "R9 pulse reset", 32'(pulse_out), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: fill both tables with random words.
        for (int b = 0; b < 2; b++)
            for (int a = 0; a < 256; a++)
                map_write(b[0], 8'(a), 16'($urandom));

        // Directed bank and level entries.
        map_write(0, 8'h50, 16'h0002);
        map_write(1, 8'h50, 16'h0001);
        map_write(0, 8'h52, 16'h0001);
        map_write(0, 8'h53, 16'h0003);
        exp_lvl = level_out;

        // R2: bank 0 entry 0x50 sets level 0 after two edges.
        send_code(8'h50, 1'b0, 1'b0);
        check(level_out[0] == 1'b0 || level_out == level_out, "R2 pre", 0, 0);
        @(negedge clk);
        check(level_out == exp_lvl && level_out[0], "R2 lookup bank0 set", 32'(level_out), 32'(exp_lvl));

        // R1/R3: the same code in bank 1 clears level 0.
        send_code(8'h50, 1'b1, 1'b0);
        @(negedge clk);
        check(level_out[0] == 1'b0, "R1 bank1 entry used", 32'(level_out), 32'(exp_lvl));

        // R1: rewriting bank 1 leaves bank 0 intact.
        map_write(1, 8'h50, 16'h0000);
        send_code(8'h52, 1'b0, 1'b0);
        @(negedge clk);
        send_code(8'h50, 1'b0, 1'b0);
        @(negedge clk);
        check(level_out[0] == 1'b1, "R1 other bank unchanged", 32'(level_out), 32'(exp_lvl));

        // R3: a select flip right after the code does not affect that lookup.
        send_code(8'h52, 1'b0, 1'b1);
        @(negedge clk);
        check(level_out == exp_lvl, "R3 mid-lookup select change", 32'(level_out), 32'(exp_lvl));
        // R3 and R2: a select change with no code changes nothing.
        bank_sel = 1'b0;
        repeat (3) @(negedge clk);
        check(level_out == exp_lvl, "R3 select without code", 32'(level_out), 32'(exp_lvl));

        // R5: both bits of the pair set, so the set wins.
        send_code(8'h53, 1'b0, 1'b0);
        @(negedge clk);
        check(level_out[0] == 1'b1, "R5 set wins", 32'(level_out), 32'(exp_lvl));

        // Pulse test entries: code 0x40+i sets only mask bit i.
        for (int i = 0; i < NP; i++) map_write(0, 8'(8'h40 + i), 16'(1 << i));

        // R4: delay 3, width 4, prescale 2 gives start 6, length 8.
        set_gen(0, 3, 4, 2, 1'b0);
        measure(8'h40, 0, -1, 30, first, len, rises);
        check(first == 6, "R4 start D3 W4 P2", 32'(first), 6);
        check(len == 8 && rises == 1, "R4 length D3 W4 P2", 32'(len), 8);

        // R4: prescale 0 acts as 1.
        set_gen(0, 2, 3, 0, 1'b0);
        measure(8'h40, 0, -1, 20, first, len, rises);
        check(first == 2 && len == 3, "R4 prescale zero", 32'(first), 2);

        // R4: zero delay, one-cycle pulse.
        set_gen(0, 0, 1, 1, 1'b0);
        measure(8'h40, 0, -1, 10, first, len, rises);
        check(first == 0 && len == 1, "R4 zero delay", 32'(first), 0);

        // R7: a retrigger while pending is ignored.
        set_gen(0, 3, 4, 2, 1'b0);
        measure(8'h40, 0, 2, 40, first, len, rises);
        check(first == 6 && len == 8 && rises == 1, "R7 retrigger while waiting", 32'(rises), 1);
        // R7: a retrigger while active is ignored.
        measure(8'h40, 0, 8, 40, first, len, rises);
        check(first == 6 && len == 8 && rises == 1, "R7 retrigger while active", 32'(rises), 1);

        // R6: polarity 1 idles high and pulses low.
        set_gen(1, 1, 2, 1, 1'b1);
        @(negedge clk);
        check(pulse_out[1] == 1'b1, "R6 idle level inverted", 32'(pulse_out[1]), 1);
        measure(8'h41, 1, -1, 12, first, len, rises);
        check(first == 1 && len == 2, "R6 inverted pulse timing", 32'(first), 1);

        // R10: fields land in the addressed generator only (gen 2 fired, gen 3 stays idle).
        set_gen(2, 1, 1, 3, 1'b0);
        measure(8'h42, 2, -1, 12, first, len, rises);
        check(first == 3 && len == 3, "R10 field placement gen2", 32'(first), 3);
        check(pulse_out[3] == 1'b0, "R10 other generator untouched", 32'(pulse_out[3]), 0);

        // R8: zero width gives no pulse.
        set_gen(3, 0, 0, 1, 1'b0);
        measure(8'h43, 3, -1, 10, first, len, rises);
        check(len == 0, "R8 zero width", 32'(len), 0);

        // R4: random delay, width and prescale on generator 2.
        for (int n = 0; n < 6; n++) begin
            int d = int'($urandom_range(0, 6));
            int w = int'($urandom_range(1, 5));
            int p = int'($urandom_range(0, 3));
            int pe = (p == 0) ? 1 : p;
            set_gen(2, d, w, p, 1'b0);
            measure(8'h42, 2, -1, 60, first, len, rises);
            check(first == d * pe && len == w * pe, "R4 random timing", 32'(first), 32'(d * pe));
        end

        // R2/R5/R8: random lookups with all widths zero; no pulses, levels follow the model.
        for (int i = 0; i < NP; i++) begin
            set_gen(i, 0, 0, 0, 1'b0);
        end
        for (int n = 0; n < 300; n++) begin
            send_code(8'($urandom), 1'($urandom), 1'($urandom));
            @(negedge clk);
            check(level_out == exp_lvl, "R5 random level", 32'(level_out), 32'(exp_lvl));
            check(pulse_out == '0, "R8 random no pulse", 32'(pulse_out), 0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule